// File: doc/BRIEF.md
# Masked Packed Integer-to-Float Converter

This block turns a vector of signed 32-bit integers into IEEE-754 single-precision values, one result per lane, in a single registered stage. The vector is 128, 256 or 512 bits wide, so it holds 4, 8 or 16 lanes. The inputs are the source vector, the old destination value, a per-lane mask, a length select, an encoding-class select and two rounding fields. The outputs are the new destination vector, a precision (inexact) flag and an illegal-encoding flag.

Three encoding classes set how the lanes around the conversion are handled. The legacy class is always 128 bits wide and leaves the destination bits above lane 3 untouched. The plain class is 128 or 256 bits wide and clears everything above the active length. The masked class adds a per-lane writemask with a merging or zeroing policy, a broadcast of source lane 0 to every lane for memory operands, and a per-operation rounding override. Instruction decode, memory access and exception delivery are handled elsewhere. The block only reports the two flags.

Top module: `cvt_unit`

## Requirements
- R1: Each converted lane holds the correctly rounded single-precision value of its signed integer, using the rounding code 00 = nearest-even, 01 = toward minus infinity, 10 = toward plus infinity, 11 = toward zero. An integer 0 gives 0x00000000 and 0x80000000 gives 0xCF000000.
- R2: `out_inexact` is 1 exactly when at least one converted lane needed rounding. Lanes that are masked off, inactive or suppressed never set it.
- R3: The length code `in_vlen` selects 0 = 4 lanes, 1 = 8 lanes, 2 or 3 = 16 lanes. Lane j sits in bits [32j+31:32j]. The legacy class (`in_enc` = 0) always uses 4 lanes. The plain class (`in_enc` = 1) treats codes 2 and 3 as 8 lanes.
- R4: In the masked class (`in_enc` = 2 or 3), while `in_mask_en` is 1, an active lane is converted only when its mask bit is 1. A lane whose mask bit is 0 keeps the old destination lane when `in_zeroing` = 0 and is written with 0 when `in_zeroing` = 1. The mask has no effect in the other classes or while `in_mask_en` is 0.
- R5: In the masked class, with `in_bcast` = 1 and `in_src_is_reg` = 0, every converted lane converts source bits [31:0].
- R6: The rounding mode is `in_op_rm` only in the masked class with 16 lanes, `in_src_is_reg` = 1 and `in_bcast` = 1. In every other case it is `in_csr_rm`. A register operand is never broadcast.
- R7: Lanes at and above the active lane count take the old destination value in the legacy class and are 0 in the plain and masked classes.
- R8: In the plain and masked classes, an `in_spec` value other than 4'b1111 sets `out_illegal`, returns the old destination unchanged and keeps `out_inexact` at 0. The legacy class ignores `in_spec`.
- R9: An operation presented with `in_valid` shows its results and `out_valid` = 1 one cycle later. A cycle without `in_valid` gives `out_valid` = 0 and both flags 0, and `out_dest` holds its value. Reset clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| in_src | input | 512 | Packed signed integer source |
| in_dest_old | input | 512 | Previous destination value |
| in_mask | input | 16 | Per-lane writemask |
| in_mask_en | input | 1 | Writemask in use (masked class only) |
| in_zeroing | input | 1 | 1 = zero masked-off lanes, 0 = merge |
| in_bcast | input | 1 | Broadcast / rounding-override bit |
| in_src_is_reg | input | 1 | Source is a register (1) or memory (0) |
| in_vlen | input | 2 | Vector length code |
| in_enc | input | 2 | Encoding class: 0 legacy, 1 plain, 2/3 masked |
| in_csr_rm | input | 2 | Global rounding field |
| in_op_rm | input | 2 | Per-operation rounding override |
| in_spec | input | 4 | Extra specifier field, must be 4'b1111 |
| out_valid | output | 1 | Result valid |
| out_dest | output | 512 | Resulting destination vector |
| out_inexact | output | 1 | Precision flag |
| out_illegal | output | 1 | Illegal-encoding flag |

## Verification
All results appear exactly one clock edge after the operation is accepted: `out_dest`, `out_inexact`, `out_illegal` and `out_valid` all come from the single output register. The bench changes inputs on the falling edge and drops `in_valid` right after the rising edge that accepts them. It samples on the next falling edge, so every comparison falls in the one cycle where that operation's results are shown. One idle cycle is checked separately to confirm that the flags clear and the vector holds.

// File: rtl/cvt_pkg.sv
`timescale 1ns/1ps
package cvt_pkg;
    localparam int LANE_W    = 32;
    localparam int MAX_LANES = 16;
    localparam int VEC_W     = LANE_W * MAX_LANES;
    localparam int EXP_BIAS  = 127;
    localparam int MAN_W     = 23;
    localparam int SPEC_W    = 4;

    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'b00,
        RM_DOWN      = 2'b01,
        RM_UP        = 2'b10,
        RM_ZERO      = 2'b11
    } rmode_e;

    typedef enum logic [1:0] {
        ENC_LEGACY     = 2'd0,
        ENC_PLAIN      = 2'd1,
        ENC_MASKED     = 2'd2,
        ENC_MASKED_ALT = 2'd3
    } enc_e;

    typedef struct packed {
        logic                 legal;
        rmode_e               rm;
        logic                 bcast;
        logic                 use_mask;
        logic                 zeroing;
        logic                 keep_upper;
        logic [MAX_LANES-1:0] active;
    } ctrl_t;

    typedef struct packed {
        logic             sign;
        logic [7:0]       exp;
        logic [MAN_W-1:0] man;
    } sp_t;

    function automatic logic [5:0] lead_zeros(logic [LANE_W-1:0] v);
        logic [5:0] n;
        n = 6'd32;
        for (int b = 0; b < LANE_W; b++) begin
            if (v[b]) n = 6'(LANE_W - 1 - b);
        end
        return n;
    endfunction

    function automatic logic [MAX_LANES-1:0] lane_span(int n);
        logic [MAX_LANES-1:0] s;
        for (int b = 0; b < MAX_LANES; b++) s[b] = (b < n);
        return s;
    endfunction
endpackage

// File: rtl/cvt_ctrl.sv
`timescale 1ns/1ps
module cvt_ctrl
    import cvt_pkg::*;
(
    input  logic [1:0]        enc,
    input  logic [1:0]        vlen,
    input  logic              mask_en,
    input  logic              zeroing,
    input  logic              bcast_bit,
    input  logic              src_is_reg,
    input  logic [1:0]        csr_rm,
    input  logic [1:0]        op_rm,
    input  logic [SPEC_W-1:0] spec,
    output ctrl_t             ctrl
);
    enc_e enc_q;
    logic is_masked;
    int   n_lanes;

    always_comb begin
        enc_q     = enc_e'(enc);
        is_masked = enc_q[1];
        unique case (enc_q)
            ENC_LEGACY: n_lanes = 4;
            ENC_PLAIN:  n_lanes = (vlen == 2'd0) ? 4 : 8;
            default:    n_lanes = (vlen == 2'd0) ? 4 : ((vlen == 2'd1) ? 8 : MAX_LANES);
        endcase

        ctrl.legal      = (enc_q == ENC_LEGACY) || (spec == {SPEC_W{1'b1}});
        ctrl.active     = lane_span(n_lanes);
        ctrl.bcast      = is_masked && bcast_bit && !src_is_reg;
        ctrl.rm         = (is_masked && src_is_reg && bcast_bit && n_lanes == MAX_LANES)
                          ? rmode_e'(op_rm) : rmode_e'(csr_rm);
        ctrl.use_mask   = is_masked && mask_en;
        ctrl.zeroing    = zeroing;
        ctrl.keep_upper = (enc_q == ENC_LEGACY);
    end
endmodule

// File: rtl/cvt_lane.sv
`timescale 1ns/1ps
module cvt_lane
    import cvt_pkg::*;
(
    input  logic [LANE_W-1:0] int_in,
    input  rmode_e            rm,
    output logic [LANE_W-1:0] fp_out,
    output logic              inexact
);
    localparam int TOP_EXP = EXP_BIAS + LANE_W - 1;

    logic              neg;
    logic [LANE_W-1:0] mag;
    logic [LANE_W-1:0] norm;
    logic [5:0]        lz;
    logic              lsb, guard, sticky, up;
    logic [24:0]       sig;
    logic [7:0]        exp_b;
    sp_t               res;

    always_comb begin
        neg     = int_in[LANE_W-1];
        mag     = neg ? (~int_in + 32'd1) : int_in;
        lz      = lead_zeros(mag);
        norm    = mag << lz;
        lsb     = norm[8];
        guard   = norm[7];
        sticky  = |norm[6:0];
        inexact = guard | sticky;
        unique case (rm)
            RM_NEAR_EVEN: up = guard & (sticky | lsb);
            RM_DOWN:      up = neg & inexact;
            RM_UP:        up = ~neg & inexact;
            default:      up = 1'b0;
        endcase
        sig   = {1'b0, norm[31:8]} + {24'd0, up};
        exp_b = 8'(TOP_EXP) - {2'b00, lz};
        res   = '0;
        if (mag != '0) begin
            res.sign = neg;
            if (sig[24]) begin
                res.exp = exp_b + 8'd1;
                res.man = '0;
            end else begin
                res.exp = exp_b;
                res.man = sig[MAN_W-1:0];
            end
        end
        fp_out = res;
    end
endmodule

// File: rtl/cvt_lane_out.sv
`timescale 1ns/1ps
module cvt_lane_out
    import cvt_pkg::*;
(
    input  logic [LANE_W-1:0] conv,
    input  logic [LANE_W-1:0] old,
    input  logic              in_span,
    input  logic              use_mask,
    input  logic              mask_bit,
    input  logic              zeroing,
    input  logic              keep_upper,
    output logic [LANE_W-1:0] lane,
    output logic              converted
);
    always_comb begin
        converted = in_span && (!use_mask || mask_bit);
        if (converted)    lane = conv;
        else if (in_span) lane = zeroing ? '0 : old;
        else              lane = keep_upper ? old : '0;
    end
endmodule

// File: rtl/cvt_unit.sv
`timescale 1ns/1ps
module cvt_unit
    import cvt_pkg::*;
#(
    parameter int NLANES = cvt_pkg::MAX_LANES
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [NLANES*LANE_W-1:0] in_src,
    input  logic [NLANES*LANE_W-1:0] in_dest_old,
    input  logic [NLANES-1:0]        in_mask,
    input  logic                     in_mask_en,
    input  logic                     in_zeroing,
    input  logic                     in_bcast,
    input  logic                     in_src_is_reg,
    input  logic [1:0]               in_vlen,
    input  logic [1:0]               in_enc,
    input  logic [1:0]               in_csr_rm,
    input  logic [1:0]               in_op_rm,
    input  logic [SPEC_W-1:0]        in_spec,
    output logic                     out_valid,
    output logic [NLANES*LANE_W-1:0] out_dest,
    output logic                     out_inexact,
    output logic                     out_illegal
);
    localparam int VW = NLANES * LANE_W;

    ctrl_t             ctrl;
    logic [VW-1:0]     dest_nx;
    logic [NLANES-1:0] lane_inx;

    cvt_ctrl u_ctrl (
        .enc        (in_enc),
        .vlen       (in_vlen),
        .mask_en    (in_mask_en),
        .zeroing    (in_zeroing),
        .bcast_bit  (in_bcast),
        .src_is_reg (in_src_is_reg),
        .csr_rm     (in_csr_rm),
        .op_rm      (in_op_rm),
        .spec       (in_spec),
        .ctrl       (ctrl)
    );

    for (genvar j = 0; j < NLANES; j++) begin : g_lane
        logic [LANE_W-1:0] src_l, conv_l;
        logic              inx_l, done_l;

        assign src_l = ctrl.bcast ? in_src[LANE_W-1:0] : in_src[j*LANE_W +: LANE_W];

        cvt_lane u_cvt (
            .int_in  (src_l),
            .rm      (ctrl.rm),
            .fp_out  (conv_l),
            .inexact (inx_l)
        );

        cvt_lane_out u_out (
            .conv       (conv_l),
            .old        (in_dest_old[j*LANE_W +: LANE_W]),
            .in_span    (ctrl.active[j]),
            .use_mask   (ctrl.use_mask),
            .mask_bit   (in_mask[j]),
            .zeroing    (ctrl.zeroing),
            .keep_upper (ctrl.keep_upper),
            .lane       (dest_nx[j*LANE_W +: LANE_W]),
            .converted  (done_l)
        );

        assign lane_inx[j] = done_l & inx_l;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_dest    <= '0;
            out_inexact <= 1'b0;
            out_illegal <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_dest    <= ctrl.legal ? dest_nx : in_dest_old;
                out_inexact <= ctrl.legal && (|lane_inx);
                out_illegal <= !ctrl.legal;
            end else begin
                out_inexact <= 1'b0;
                out_illegal <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cvt_unit_chk.sv
`timescale 1ns/1ps
module cvt_unit_chk
    import cvt_pkg::*;
#(
    parameter int NLANES = cvt_pkg::MAX_LANES
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic [NLANES*LANE_W-1:0] in_src,
    input logic [NLANES*LANE_W-1:0] in_dest_old,
    input logic [NLANES-1:0]        in_mask,
    input logic                     in_mask_en,
    input logic                     in_zeroing,
    input logic                     in_bcast,
    input logic                     in_src_is_reg,
    input logic [1:0]               in_vlen,
    input logic [1:0]               in_enc,
    input logic [1:0]               in_csr_rm,
    input logic [1:0]               in_op_rm,
    input logic [SPEC_W-1:0]        in_spec,
    input logic                     out_valid,
    input logic [NLANES*LANE_W-1:0] out_dest,
    input logic                     out_inexact,
    input logic                     out_illegal
);
    localparam int VW = NLANES * LANE_W;

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_inexact && !out_illegal && $stable(out_dest)));

    // R8
    bad_spec_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_enc != 2'd0 && in_spec != 4'hF)
        |=> (out_illegal && !out_inexact && out_dest == $past(in_dest_old)));

    // R8
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> !out_inexact);

    // R7
    legacy_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_enc == 2'd0)
        |=> out_dest[VW-1:128] == $past(in_dest_old[VW-1:128]));

    // R7
    plain_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_enc == 2'd1 && in_spec == 4'hF)
        |=> out_dest[VW-1:256] == '0);

    // R4
    zero_all_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_enc[1] && in_spec == 4'hF && in_mask_en && in_zeroing && in_mask == '0)
        |=> (out_dest == '0 && !out_inexact));
endmodule

bind cvt_unit cvt_unit_chk #(.NLANES(NLANES)) u_chk (.*);

// File: tb/cvt_unit_bench.sv
`timescale 1ns/1ps
module cvt_unit_bench;
    localparam int NL = 16;
    localparam int VW = NL * 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [VW-1:0] in_src, in_dest_old;
    logic [NL-1:0] in_mask;
    logic          in_mask_en, in_zeroing, in_bcast, in_src_is_reg;
    logic [1:0]    in_vlen, in_enc, in_csr_rm, in_op_rm;
    logic [3:0]    in_spec;
    logic          out_valid, out_inexact, out_illegal;
    logic [VW-1:0] out_dest;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    cvt_unit u_cvt_unit (.*);

    typedef struct packed {
        logic [31:0] val;
        logic [1:0]  rm;
        logic [31:0] expv;
        logic        inx;
    } vec_t;

    localparam vec_t TBL [0:12] = '{
        '{32'h00000000, 2'b00, 32'h00000000, 1'b0},
        '{32'h00000001, 2'b00, 32'h3F800000, 1'b0},
        '{32'hFFFFFFFF, 2'b00, 32'hBF800000, 1'b0},
        '{32'h00000003, 2'b00, 32'h40400000, 1'b0},
        '{32'hFFFFFFFB, 2'b11, 32'hC0A00000, 1'b0},
        '{32'h80000000, 2'b00, 32'hCF000000, 1'b0},
        '{32'h01000001, 2'b00, 32'h4B800000, 1'b1},
        '{32'h01000001, 2'b10, 32'h4B800001, 1'b1},
        '{32'h01000003, 2'b00, 32'h4B800002, 1'b1},
        '{32'hFEFFFFFF, 2'b01, 32'hCB800001, 1'b1},
        '{32'hFEFFFFFF, 2'b10, 32'hCB800000, 1'b1},
        '{32'h7FFFFFFF, 2'b00, 32'h4F000000, 1'b1},
        '{32'h7FFFFFFF, 2'b11, 32'h4EFFFFFF, 1'b1}
    };

    // Reference conversion by magnitude search and remainder comparison.
    function automatic logic [32:0] ref_cvt(logic [31:0] v, logic [1:0] rm);
        longint m, q, rem, half;
        int e, sh;
        logic s, up;
        s = v[31];
        m = s ? (64'sd4294967296 - longint'(v)) : longint'(v);
        if (m == 0) return 33'd0;
        e = 0;
        while ((m >> (e + 1)) != 0) e++;
        if (e <= 23) return {1'b0, s, 8'(e + 127), 23'((m << (23 - e)) & 64'h7FFFFF)};
        sh = e - 23;
        q = m >> sh;
        rem = m & ((64'd1 << sh) - 1);
        half = 64'd1 << (sh - 1);
        case (rm)
            2'b00:   up = (rem > half) || (rem == half && q[0]);
            2'b01:   up = s && rem != 0;
            2'b10:   up = !s && rem != 0;
            default: up = 1'b0;
        endcase
        if (up) q = q + 1;
        if (q == (64'd1 << 24)) begin q = q >> 1; e++; end
        return {rem != 0, s, 8'(e + 127), 23'(q & 64'h7FFFFF)};
    endfunction

    // Expected {illegal, inexact, dest} from the requirements.
    function automatic logic [VW+1:0] model();
        int n;
        logic legal, msk, bc, ix;
        logic [1:0] rm;
        logic [32:0] r;
        logic [VW-1:0] d;
        msk = in_enc[1];
        case (in_enc)
            2'd0: n = 4;
            2'd1: n = (in_vlen == 0) ? 4 : 8;
            default: n = (in_vlen == 0) ? 4 : (in_vlen == 1 ? 8 : 16);
        endcase
        legal = (in_enc == 0) || (in_spec == 4'hF);
        bc = msk && in_bcast && !in_src_is_reg;
        rm = (msk && in_src_is_reg && in_bcast && n == 16) ? in_op_rm : in_csr_rm;
        ix = 1'b0;
        for (int j = 0; j < NL; j++) begin
            if (j < n) begin
                if (!(msk && in_mask_en) || in_mask[j]) begin
                    r = ref_cvt(bc ? in_src[31:0] : in_src[j*32 +: 32], rm);
                    d[j*32 +: 32] = r[31:0];
                    ix = ix | r[32];
                end else begin
                    d[j*32 +: 32] = in_zeroing ? 32'd0 : in_dest_old[j*32 +: 32];
                end
            end else begin
                d[j*32 +: 32] = (in_enc == 0) ? in_dest_old[j*32 +: 32] : 32'd0;
            end
        end
        if (!legal) begin d = in_dest_old; ix = 1'b0; end
        return {!legal, ix, d};
    endfunction

    task automatic chk(string req, logic [VW-1:0] got, logic [VW-1:0] exp_v);
        n_chk++;
        if (got !== exp_v) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", req, got, exp_v);
        end
    endtask

    task automatic defaults();
        in_valid = 0; in_src = '0; in_dest_old = '0; in_mask = '0;
        in_mask_en = 0; in_zeroing = 0; in_bcast = 0; in_src_is_reg = 1;
        in_vlen = 0; in_enc = 0; in_csr_rm = 0; in_op_rm = 0; in_spec = 4'hF;
    endtask

    // Called at a falling edge with inputs set; results are due one edge later.
    task automatic fire(string req);
        logic [VW+1:0] e;
        e = model();
        in_valid = 1;
        @(posedge clk);
        #1 in_valid = 0;
        @(negedge clk);
        chk({req, " dest"}, out_dest, e[VW-1:0]);
        chk({req, " inexact"}, VW'(out_inexact), VW'(e[VW]));
        chk({req, " illegal"}, VW'(out_illegal), VW'(e[VW+1]));
        chk("R9 valid", VW'(out_valid), VW'(1));
    endtask

    function automatic logic [VW-1:0] fill(logic [31:0] v);
        logic [VW-1:0] r;
        for (int j = 0; j < NL; j++) r[j*32 +: 32] = v;
        return r;
    endfunction

    function automatic logic [VW-1:0] ramp(int base, int step);
        logic [VW-1:0] r;
        for (int j = 0; j < NL; j++) r[j*32 +: 32] = 32'(base + j * step);
        return r;
    endfunction

    initial begin
        #500000;
        n_chk++; n_fail++;
        $display("FAIL R9 watchdog expired got=hang exp=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        defaults();
        rst = 1;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 reset dest", out_dest, '0);
        chk("R9 reset flags", VW'({out_valid, out_inexact, out_illegal}), '0);
        rst = 0;
        @(negedge clk);

        // R1 R2 R7: table walk in legacy class, four lanes, upper kept
        foreach (TBL[k]) begin
            defaults();
            in_src = fill(TBL[k].val);
            in_dest_old = ramp(32'h11110000, 3);
            in_csr_rm = TBL[k].rm;
            in_valid = 1;
            @(posedge clk);
            #1 in_valid = 0;
            @(negedge clk);
            chk("R1 lane0", VW'(out_dest[31:0]), VW'(TBL[k].expv));
            chk("R1 lane3", VW'(out_dest[127:96]), VW'(TBL[k].expv));
            chk("R2 inexact", VW'(out_inexact), VW'(TBL[k].inx));
            chk("R7 legacy upper", VW'(out_dest[VW-1:128]), VW'(in_dest_old[VW-1:128]));
        end

        // R4 merging, 16 lanes
        defaults();
        in_enc = 2; in_vlen = 2; in_mask_en = 1; in_mask = 16'hA5A5;
        in_src = ramp(-7000, 1000); in_dest_old = ramp(32'hDEAD0000, 1);
        fire("R4 merge");

        // R4 R7 zeroing, 8 lanes
        in_vlen = 1; in_zeroing = 1; in_mask = 16'hFF0F;
        fire("R4 R7 zeroing");

        // R2 masked-off inexact lane must not raise the flag, then it must
        defaults();
        in_enc = 2; in_vlen = 2; in_mask_en = 1; in_mask = 16'hFFFD;
        in_src = ramp(5, 1); in_src[63:32] = 32'h01000001;
        fire("R2 masked inexact off");
        chk("R2 flag clear", VW'(out_inexact), VW'(0));
        in_mask = 16'hFFFF;
        fire("R2 masked inexact on");
        chk("R2 flag set", VW'(out_inexact), VW'(1));

        // R5 broadcast from memory
        defaults();
        in_enc = 2; in_vlen = 2; in_bcast = 1; in_src_is_reg = 0;
        in_src = ramp(100, 7); in_src[31:0] = 32'h01000003;
        fire("R5 broadcast");
        chk("R5 value", out_dest, fill(32'h4B800002));

        // R6 override at 16 lanes with register operand
        defaults();
        in_enc = 2; in_vlen = 2; in_bcast = 1; in_src_is_reg = 1;
        in_csr_rm = 2'b00; in_op_rm = 2'b10; in_src = fill(32'h01000001);
        fire("R6 override");
        chk("R6 value", out_dest, fill(32'h4B800001));
        in_vlen = 1;
        fire("R6 no override at 8 lanes");
        chk("R6 csr value", out_dest[255:0], fill(32'h4B800000) >> 256);
        in_vlen = 2; in_src_is_reg = 0;
        fire("R6 memory uses csr");

        // R3 R4 R7 plain class: mask ignored, codes 2 and 3 act as 8 lanes
        defaults();
        in_enc = 1; in_vlen = 3; in_mask_en = 1; in_mask = '0; in_zeroing = 1;
        in_src = ramp(-3, 11); in_dest_old = fill(32'hAAAA5555);
        fire("R3 R4 R7 plain");
        in_vlen = 0;
        fire("R3 plain 4 lanes");

        // R8 illegal specifier in plain and masked classes; legacy ignores it
        defaults();
        in_enc = 1; in_spec = 4'hE; in_src = fill(32'h01000001);
        in_dest_old = ramp(32'h0BAD0000, 5);
        fire("R8 illegal plain");
        chk("R8 flag", VW'(out_illegal), VW'(1));
        in_enc = 2; in_spec = 4'h0;
        fire("R8 illegal masked");
        in_enc = 0;
        fire("R8 legacy ignores spec");
        chk("R8 legacy legal", VW'(out_illegal), VW'(0));

        // R9 idle cycle: flags clear, dest held
        begin
            logic [VW-1:0] held;
            held = out_dest;
            @(negedge clk);
            chk("R9 idle valid", VW'({out_valid, out_inexact, out_illegal}), '0);
            chk("R9 idle hold", out_dest, held);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule